// File: doc/BRIEF.md
# Dual-Stage Jittered Sample Interval Counter

This block decides which members of a profiling event population are picked for sampling. A primary down-counter counts population strobes against a programmed interval. When it expires, the block either picks a sample at once or, in random mode, loads a secondary down-counter with a pseudorandom value. The sample point then comes that many strobes later. The secondary stage spreads the sample points so that they do not lock onto periodic program behaviour.

Both counts are visible through one 64-bit word that software saves and restores across context switches. Software writes zero to the word before it starts a new sampling session. A build-time parameter removes the random stage altogether. The block does not handle the captured sample, access permissions, or storage of the interval value.

Top module: `sample_interval_ctr`

## Requirements
- R1: After reset, both counts read zero, `sample_o` is low and the pseudorandom register holds its seed 0xA5.
- R2: `rd_data_o` shows the primary count in bits [31:0] and the secondary count in bits [63:56]. Bits [55:32] always read zero.
- R3: When `wr_en_i` is high, the next cycle's word takes bits [31:0] and [63:56] of `wr_data_i`. Bits [55:32] of the write are ignored. The write takes priority over a reload or decrement in the same cycle, and no sample is picked in that cycle.
- R4: A strobe (`event_i` high while `prof_en_i` is high) with the primary count above one lowers the primary count by exactly one.
- R5: A strobe that finds the primary count at one or zero, with the secondary count at zero and random mode off, reloads the primary count from `interval_i`. `sample_o` is then high for one cycle, in the cycle after that strobe.
- R6: If random mode is on for that same expiring strobe, the primary count is still reloaded. The secondary count takes the value (pseudorandom register − 1) mod 256, and no sample is picked unless that value is zero.
- R7: While the secondary count is nonzero, each strobe lowers it by one and also steps the primary count (decrement, or reload at expiry without new jitter). The strobe that takes the secondary count from one to zero picks a sample.
- R8: If the jitter value is zero, the expiring strobe picks a sample at once and the secondary count stays zero.
- R9: In the first cycle that `prof_en_i` is high after a low cycle, a zero primary count is reloaded from `interval_i`. A strobe in that cycle has no further effect.
- R10: While `prof_en_i` is low, neither count changes and `sample_o` stays low, whatever `event_i` does.
- R11: With `HAS_RAND` = 0, bits [63:56] read zero and ignore writes, and random mode behaves as if it were off.
- R12: The pseudorandom register updates on every clock as q <= {q[6:0], q[7]^q[5]^q[4]^q[3]}. The jitter uses the value held at the expiring strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | One strobe per population member |
| prof_en_i | input | 1 | Profiling enable level |
| rand_mode_i | input | 1 | Request random jitter on expiry |
| interval_i | input | 32 | Primary reload value |
| wr_en_i | input | 1 | Software write of the count word |
| wr_data_i | input | 64 | Count word to write |
| rd_data_o | output | 64 | Current count word |
| sample_o | output | 1 | One-cycle sample-selected pulse |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that a write cycle is always excluded from the decrement and reload rules, so every counting property is guarded by the absence of `wr_en_i`. The stimulus drives all inputs on the falling edge, and it keeps `interval_i` steady during a strobe run so that the reload value is known in each phase. For the zero-jitter case, the bench waits on idle cycles until its own copy of the pseudorandom sequence reaches one and then gives the expiring strobe. Both build variants receive the same input stream.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int WORD_W = 64;

  function automatic logic [7:0] lfsr8_next(input logic [7:0] q, input logic [7:0] taps);
    return {q[6:0], ^(q & taps)};
  endfunction
endpackage

// File: rtl/sic_lfsr.sv
module sic_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= SEED;
    else         q_q <= {q_q[W-2:0], ^(q_q & TAPS)};
  end

  assign q_o = q_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0); // R12
endmodule

// File: rtl/sic_pri_ctr.sv
module sic_pri_ctr #(
  parameter int PRI_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic             wr_i,
  input  logic [PRI_W-1:0] wr_val_i,
  input  logic [PRI_W-1:0] interval_i,
  output logic [PRI_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [PRI_W-1:0] cnt_q, cnt_d;

  // count of one or zero expires on a strobe
  assign expire_o = step_i && (cnt_q[PRI_W-1:1] == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)          cnt_d = wr_val_i;
    else if (reload_i) cnt_d = interval_i;
    else if (expire_o) cnt_d = interval_i;
    else if (step_i)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_PRI_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && !reload_i && cnt_q > PRI_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_PRI_EXPIRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !wr_i) |=> cnt_q == $past(interval_i)); // R5
endmodule

// File: rtl/sic_sec_ctr.sv
module sic_sec_ctr #(
  parameter int SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             pri_expire_i,
  input  logic             rand_en_i,
  input  logic [SEC_W-1:0] jitter_i,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] wr_val_i,
  output logic [SEC_W-1:0] cnt_o,
  output logic             fire_o
);
  logic [SEC_W-1:0] cnt_q, cnt_d;
  logic             active;
  logic             arm;

  assign active = cnt_q != '0;
  assign arm    = step_i && !active && pri_expire_i && rand_en_i;

  always_comb begin
    if (active)             fire_o = step_i && (cnt_q == SEC_W'(1));
    else if (pri_expire_i)  fire_o = !rand_en_i || (jitter_i == '0);
    else                    fire_o = 1'b0;
    fire_o = fire_o && step_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)                  cnt_d = wr_val_i;
    else if (step_i && active) cnt_d = cnt_q - 1'b1;
    else if (arm)              cnt_d = jitter_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_SEC_JITTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !wr_i) |=> cnt_q == $past(jitter_i)); // R6
  AST_SEC_LAST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i && cnt_q == SEC_W'(1)) |=> cnt_q == '0); // R7
  AST_SEC_ZERO_JITTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !wr_i && jitter_i == '0) |=> cnt_q == '0); // R8
endmodule

// File: rtl/sample_interval_ctr.sv
module sample_interval_ctr
  import sic_pkg::*;
#(
  parameter int          PRI_W    = 32,
  parameter int          SEC_W    = 8,
  parameter bit          HAS_RAND = 1'b1,
  parameter logic [7:0]  LFSR_SEED = 8'hA5,
  parameter logic [7:0]  LFSR_TAPS = 8'hB8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  logic              prof_en_i,
  input  logic              rand_mode_i,
  input  logic [PRI_W-1:0]  interval_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              sample_o
);
  localparam int SEC_LSB = WORD_W - SEC_W;
  localparam int PAD_W   = SEC_LSB - PRI_W;

  logic             en_q;
  logic             sample_q;
  logic [PRI_W-1:0] pri_cnt;
  logic [SEC_W-1:0] sec_cnt;
  logic             pri_expire;
  logic             fire;
  logic             reload;
  logic             step;
  logic             unused_pad;

  assign unused_pad = ^wr_data_i[SEC_LSB-1:PRI_W];

  assign reload = prof_en_i && !en_q && (pri_cnt == '0) && !wr_en_i;
  assign step   = prof_en_i && event_i && !wr_en_i && !reload;

  sic_pri_ctr #(.PRI_W(PRI_W)) u_pri (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .reload_i   (reload),
    .wr_i       (wr_en_i),
    .wr_val_i   (wr_data_i[PRI_W-1:0]),
    .interval_i (interval_i),
    .cnt_o      (pri_cnt),
    .expire_o   (pri_expire)
  );

  generate
    if (HAS_RAND) begin : g_rand
      logic [SEC_W-1:0] lfsr_q;
      logic [SEC_W-1:0] jitter;

      sic_lfsr #(.W(SEC_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .q_o    (lfsr_q)
      );

      assign jitter = lfsr_q - SEC_W'(1);

      sic_sec_ctr #(.SEC_W(SEC_W)) u_sec (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .step_i       (step),
        .pri_expire_i (pri_expire),
        .rand_en_i    (rand_mode_i),
        .jitter_i     (jitter),
        .wr_i         (wr_en_i),
        .wr_val_i     (wr_data_i[WORD_W-1:SEC_LSB]),
        .cnt_o        (sec_cnt),
        .fire_o       (fire)
      );
    end else begin : g_plain
      logic unused_rand;
      assign unused_rand = rand_mode_i ^ (^wr_data_i[WORD_W-1:SEC_LSB]);
      assign sec_cnt     = '0;
      assign fire        = pri_expire;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      en_q     <= prof_en_i;
      sample_q <= fire;
    end
  end

  assign rd_data_o = {sec_cnt, {PAD_W{1'b0}}, pri_cnt};
  assign sample_o  = sample_q;

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[PRI_W-1:0] == $past(wr_data_i[PRI_W-1:0])); // R3
  AST_WRITE_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !sample_o); // R3
  AST_ENABLE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> rd_data_o[PRI_W-1:0] == $past(interval_i)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prof_en_i && !wr_en_i) |=> $stable(rd_data_o)); // R10
  AST_IDLE_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prof_en_i |=> !sample_o); // R10
endmodule

// File: tb/sample_interval_ctr_test.sv
module sample_interval_ctr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev = 1'b0, en = 1'b0, rnd = 1'b0, wr = 1'b0;
  logic [31:0] ival = '0;
  logic [63:0] wd = '0;
  logic [63:0] rd_a, rd_b;
  logic        smp_a, smp_b;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // reference state: index 0 random build, index 1 plain build
  logic [31:0] m_pri [2];
  logic [7:0]  m_sec [2];
  bit          m_enq [2];
  bit          m_smp [2];
  logic [7:0]  m_lfsr;

  always #5 clk = ~clk;

  sample_interval_ctr uut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .prof_en_i(en), .rand_mode_i(rnd),
    .interval_i(ival), .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd_a), .sample_o(smp_a));

  sample_interval_ctr #(.HAS_RAND(1'b0)) uut_plain (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .prof_en_i(en), .rand_mode_i(rnd),
    .interval_i(ival), .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd_b), .sample_o(smp_b));

  function automatic logic [63:0] m_word(int k);
    return {m_sec[k], 24'h0, m_pri[k]};
  endfunction

  task automatic model_one(int k);
    bit has = (k == 0);
    bit rise = en && !m_enq[k];
    bit rl = rise && (m_pri[k] == 0) && !wr;
    bit st = en && ev && !wr && !rl;
    bit pexp = (m_pri[k] <= 1);
    logic [7:0] jit = m_lfsr - 8'd1;
    m_smp[k] = 1'b0;
    if (wr) begin
      m_pri[k] = wd[31:0];
      m_sec[k] = has ? wd[63:56] : 8'h0;
    end else if (rl) begin
      m_pri[k] = ival;
    end else if (st) begin
      if (m_sec[k] != 0) begin
        if (m_sec[k] == 1) m_smp[k] = 1'b1;
        m_sec[k] = m_sec[k] - 8'd1;
        m_pri[k] = pexp ? ival : m_pri[k] - 1;
      end else if (pexp) begin
        m_pri[k] = ival;
        if (has && rnd) begin
          if (jit == 0) m_smp[k] = 1'b1;
          else          m_sec[k] = jit;
        end else m_smp[k] = 1'b1;
      end else m_pri[k] = m_pri[k] - 1;
    end
    m_enq[k] = en;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_pri[k] = '0; m_sec[k] = '0; m_enq[k] = 1'b0; m_smp[k] = 1'b0;
      end
      m_lfsr = 8'hA5;
    end else begin
      model_one(0);
      model_one(1);
      m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end
  end

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check64(cur_req, "word rand build", rd_a, m_word(0));
      check64(cur_req, "sample rand build", {63'h0, smp_a}, {63'h0, m_smp[0]});
      check64(cur_req, "word plain build", rd_b, m_word(1));
      check64(cur_req, "sample plain build", {63'h0, smp_b}, {63'h0, m_smp[1]});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      finish_run();
    end
  end

  task automatic tick(bit e);
    ev = e;
    @(negedge clk);
    ev = 1'b0;
    wr = 1'b0;
  endtask

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    check64("R1", "word after reset", rd_a, 64'h0);
    check64("R1", "sample after reset", {63'h0, smp_a}, 64'h0);

    // R10 strobes while disabled
    cur_req = "R10";
    ival = 32'd5;
    repeat (6) tick(1'b1);
    check64("R10", "word while disabled", rd_a, 64'h0);

    // R9 enable with zero count, strobe in same cycle ignored
    cur_req = "R9";
    en = 1'b1;
    tick(1'b1);
    check64("R9", "reload on enable", rd_a, 64'd5);

    // R4 and R5 plain spacing
    cur_req = "R4";
    tick(1'b1);
    check64("R4", "one decrement", rd_a, 64'd4);
    cur_req = "R5";
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1'b1);
      if (smp_a) hits++;
    end
    check64("R5", "samples in 20 strobes interval 5", 64'(hits), 64'd4);
    repeat (3) tick(1'b0);

    // R3 write priority and field layout, R2 reserved bits, R11 plain build
    cur_req = "R3";
    wr = 1'b1; wd = 64'hFFFF_FFFF_FFFF_FFFF;
    tick(1'b1);
    check64("R3", "write wins over strobe", rd_a, 64'hFF00_0000_FFFF_FFFF);
    check64("R2", "reserved bits read zero", {40'h0, rd_a[55:32]}, 64'h0);
    check64("R11", "plain build secondary", rd_b, 64'h0000_0000_FFFF_FFFF);
    check64("R3", "no sample on write", {63'h0, smp_a}, 64'h0);

    // R6 jitter load
    cur_req = "R6";
    wr = 1'b1; wd = 64'h1;
    tick(1'b0);
    rnd = 1'b1;
    ival = 32'd3;
    begin
      logic [7:0] jexp;
      jexp = m_lfsr - 8'd1;
      tick(1'b1);
      if (jexp != 0) begin
        check64("R6", "jitter loaded", {56'h0, rd_a[63:56]}, {56'h0, jexp});
        check64("R6", "no sample yet", {63'h0, smp_a}, 64'h0);
      end
      check64("R11", "plain build samples", {63'h0, smp_b}, 64'h1);
    end

    // R7 run secondary to zero with primary expiring along the way
    cur_req = "R7";
    hits = 0;
    for (int i = 0; i < 300 && hits == 0; i++) begin
      tick(1'b1);
      if (smp_a) hits++;
    end
    check64("R7", "secondary sample seen", 64'(hits), 64'd1);
    check64("R7", "secondary empty after sample", {56'h0, rd_a[63:56]}, 64'h0);

    // R8 zero jitter
    cur_req = "R8";
    wr = 1'b1; wd = 64'h1;
    tick(1'b0);
    while (m_lfsr != 8'h01) tick(1'b0);
    tick(1'b1);
    check64("R8", "immediate sample", {63'h0, smp_a}, 64'h1);
    check64("R8", "secondary stays zero", {56'h0, rd_a[63:56]}, 64'h0);

    // R12 long random run compared every cycle
    cur_req = "R12";
    ival = 32'd2;
    for (int i = 0; i < 2000; i++) tick((i % 3) != 1);

    // R10 disable mid-run
    cur_req = "R10";
    en = 1'b0;
    begin
      logic [63:0] held;
      tick(1'b1);
      held = rd_a;
      repeat (10) tick(1'b1);
      check64("R10", "frozen while disabled", rd_a, held);
    end
    en = 1'b1;
    cur_req = "R9";
    repeat (20) tick(1'b1);

    finish_run();
  end
endmodule